// File: doc/BRIEF.md
# Stepping Debug Clock Generator

This block turns one fast input clock into a pair of slow, complementary system clocks for a processor that must be paused, single-stepped or slowed while it is debugged. When no controls are active, the primary output toggles at half the input rate: it is high for one input cycle and low for the next. The secondary output is high only while the primary is low in a running cycle, so the two are in antiphase.

Three controls act on both outputs. A hold level parks the generator with both clocks low. While hold is set, each rising edge on a step input releases one complete output cycle. A 20-bit divide value stretches execution by inserting a number of idle primary periods, with both clocks low, after every pulse. Both outputs come straight from flip-flops, so they carry no glitches. Hold, step and the gap are applied only at a period boundary, so a pulse is never shortened.

Top module: `stepclk_gen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both outputs are low after that edge. After `rst` falls, if `hold` is low and `div_limit` is zero, `clk_pri` is high in the first cycle.
- R2: When running ungated, `clk_pri` is high for exactly one input cycle and low for the next, so consecutive rising edges of `clk_pri` are 2 input cycles apart.
- R3: `clk_pri` and `clk_sec` are never high together. Every high cycle of `clk_pri` is followed directly by one high cycle of `clk_sec`. Both are low while the generator is stopped.
- R4: While `hold` stays high and no step is pending, no new `clk_pri` pulse starts and both outputs stay low. A cycle already in progress finishes first.
- R5: With `hold` high, each rising edge on `step` produces exactly one full output cycle: one `clk_pri` high cycle, then one `clk_sec` high cycle. `step` passes two synchronizer flops and an edge detector, so `clk_pri` rises on the fourth rising edge of `clk` that samples `step` high, counting from the first.
- R6: A rising edge on `step` while `hold` is low has no effect on the outputs, and it is not remembered for later.
- R7: After each pulse ends, with `hold` low and a nonzero `div_limit` of N, both outputs stay low for N primary periods, which is 2N input cycles. Rising edges of `clk_pri` are therefore 2N+2 cycles apart. `div_limit` is sampled at the start of each gap, so a new value applies from the next gap.
- R8: When `div_limit` is zero, no gap is inserted.
- R9: Reset discards a step edge that has been seen but not yet served, so no pulse follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze request, synchronous to `clk` |
| step | input | 1 | Single-step request, asynchronous and edge-sensitive |
| div_limit | input | 20 | Number of idle primary periods after each pulse; zero means none |
| clk_pri | output | 1 | Primary generated clock |
| clk_sec | output | 1 | Secondary generated clock, in antiphase with the primary |

## Verification
The assertions assume that `hold` and `div_limit` are synchronous to `clk`, which means they change only between its rising edges. The bench drives every input on the falling edge, which meets this assumption. `step` may arrive at any time, but the bench keeps successive step edges far enough apart that each is served before the next one arrives. No assertion depends on two step edges merging. The bench changes `div_limit` while a gap is running, so the rule that the value is sampled at the start of each gap is exercised against the reference model.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

    // Output phase of the generator; one state per input-clock cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // stopped, both outputs low
        PH_HIGH = 2'd1,   // primary high
        PH_LOW  = 2'd2,   // secondary high
        PH_GAP  = 2'd3    // divide gap, both outputs low
    } phase_e;

    typedef struct packed {
        logic pri;
        logic sec;
    } clk_pair_t;

    function automatic clk_pair_t pair_for(input phase_e ph);
        clk_pair_t p;
        p.pri = (ph == PH_HIGH);
        p.sec = (ph == PH_LOW);
        return p;
    endfunction

endpackage

// File: rtl/stepclk_step_sync.sv
module stepclk_step_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    input  logic hold,
    input  logic consume,
    output logic pending
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              edge_seen;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= step_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign edge_seen = sync_q[STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev_q  <= sync_q[STAGES-1];
            pending <= hold & ((pending & ~consume) | edge_seen);
        end
    end

    // R6: a step can only be pending after a cycle with hold set
    assert_pend_needs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        pending |-> $past(hold));

endmodule

// File: rtl/stepclk_gap_timer.sv
module stepclk_gap_timer #(
    parameter int LIMIT_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LIMIT_W-1:0] limit,
    output logic               busy,
    output logic               last
);
    localparam int CNT_W = LIMIT_W + 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (load)      cnt_q <= {limit, 1'b0};
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CNT_W'(1));

    // R7: a running gap does not end before its final cycle
    assert_gap_continues_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && !load) |=> busy);

endmodule

// File: rtl/stepclk_gen.sv
module stepclk_gen
    import stepclk_pkg::*;
#(
    parameter int LIMIT_W     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               step,
    input  logic [LIMIT_W-1:0] div_limit,
    output logic               clk_pri,
    output logic               clk_sec
);
    phase_e    ph_q, ph_d;
    clk_pair_t out_q;
    logic      consume, gap_load, gap_busy, gap_last, step_pend, at_bnd;

    stepclk_step_sync #(.STAGES(SYNC_STAGES)) u_step (
        .clk(clk), .rst(rst), .step_in(step), .hold(hold),
        .consume(consume), .pending(step_pend)
    );

    stepclk_gap_timer #(.LIMIT_W(LIMIT_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .limit(div_limit),
        .busy(gap_busy), .last(gap_last)
    );

    // A boundary is any cycle where a new period may be chosen.
    assign at_bnd = (ph_q != PH_HIGH) && !((ph_q == PH_GAP) && !gap_last);

    always_comb begin
        ph_d     = ph_q;
        consume  = 1'b0;
        gap_load = 1'b0;
        if (ph_q == PH_HIGH) begin
            ph_d = PH_LOW;
        end else if (at_bnd) begin
            if ((ph_q == PH_LOW) && !hold && (div_limit != '0)) begin
                ph_d     = PH_GAP;
                gap_load = 1'b1;
            end else if (hold) begin
                if (step_pend) begin
                    ph_d    = PH_HIGH;
                    consume = 1'b1;
                end else begin
                    ph_d = PH_IDLE;
                end
            end else begin
                ph_d = PH_HIGH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            out_q <= '0;
        end else begin
            ph_q  <= ph_d;
            out_q <= pair_for(ph_d);
        end
    end

    assign clk_pri = out_q.pri;
    assign clk_sec = out_q.sec;

    // R3: outputs never overlap
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(clk_pri && clk_sec));

    // R2: a primary pulse lasts one cycle and hands over to the secondary
    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
        clk_pri |=> (!clk_pri && clk_sec));

    // R3: the secondary only rises right after a primary pulse
    assert_sec_follows_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_sec) |-> $past(clk_pri));

    // R4, R5: while held, a new pulse needs a pending step
    assert_held_needs_step_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_pri) && $past(hold)) |-> $past(step_pend));

    // R7: both outputs are quiet while the gap timer runs
    assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        gap_busy |-> (!clk_pri && !clk_sec));

    // R8: with no hold and no limit, the secondary is followed by the primary
    assert_no_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_sec && !hold && (div_limit == '0)) |=> clk_pri);

endmodule

// File: tb/stepclk_gen_tb.sv
module stepclk_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic        step = 1'b0;
    logic [19:0] div_limit = '0;
    logic        clk_pri, clk_sec;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int last_rise = 0;
    int last_int = 0;
    logic prev_pri = 1'b0;
    logic started = 1'b0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 primary high, 2 secondary high, 3 gap
    int m_ph = 0;
    int m_gap = 0;
    bit m_pend = 0;
    bit step_hist[$] = '{0, 0, 0};

    always #2 clk = ~clk;

    stepclk_gen u_dut (
        .clk(clk), .rst(rst), .hold(hold), .step(step),
        .div_limit(div_limit), .clk_pri(clk_pri), .clk_sec(clk_sec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        started <= 1'b1;
        if (rst) begin
            m_ph = 0; m_gap = 0; m_pend = 0;
            step_hist = '{0, 0, 0};
        end else begin
            bit saw_edge;
            bit take;
            bit free;
            int nxt;
            saw_edge = step_hist[1] && !step_hist[2];
            take = 0;
            nxt = m_ph;
            free = (m_ph == 0) || (m_ph == 2) || (m_ph == 3 && m_gap == 1);
            if (m_ph == 1) nxt = 2;
            else if (m_ph == 3 && m_gap > 1) begin nxt = 3; m_gap--; end
            else if (free) begin
                if (m_ph == 3) m_gap = 0;
                if (m_ph == 2 && !hold && div_limit != 0) begin
                    nxt = 3; m_gap = 2 * int'(div_limit);
                end else if (hold) begin
                    if (m_pend) begin nxt = 1; take = 1; end
                    else nxt = 0;
                end else nxt = 1;
            end
            m_pend = hold && ((m_pend && !take) || saw_edge);
            void'(step_hist.pop_back());
            step_hist.push_front(step);
            m_ph = nxt;
        end
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check(clk_pri === (m_ph == 1), {cur_req, " clk_pri vs model"}, int'(clk_pri), int'(m_ph == 1));
            check(clk_sec === (m_ph == 2), {cur_req, " clk_sec vs model"}, int'(clk_sec), int'(m_ph == 2));
        end
        if (clk_pri === 1'b1 && !prev_pri) begin
            rise_cnt++;
            last_int = cyc - last_rise;
            last_rise = cyc;
        end
        prev_pri = (clk_pri === 1'b1);
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        run(4);
        check(clk_pri == 1'b0 && clk_sec == 1'b0, "R1 reset low", int'({clk_pri, clk_sec}), 0);
        rst = 1'b0;
        run(1);
        check(clk_pri == 1'b1, "R1 first pulse", int'(clk_pri), 1);

        cur_req = "R2";
        run(20);
        check(last_int == 2, "R2 ungated period", last_int, 2);
        check(last_int == 2, "R8 zero limit no gap", last_int, 2);

        cur_req = "R7";
        div_limit = 20'd3;
        run(40);
        check(last_int == 8, "R7 gap of 3", last_int, 8);
        div_limit = 20'd1;
        run(30);
        check(last_int == 4, "R7 gap of 1", last_int, 4);

        cur_req = "R4";
        div_limit = '0;
        hold = 1'b1;
        run(10);
        base = rise_cnt;
        run(20);
        check(rise_cnt == base, "R4 held no pulses", rise_cnt, base);
        check(clk_pri == 1'b0 && clk_sec == 1'b0, "R3 stopped low", int'({clk_pri, clk_sec}), 0);

        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            base = rise_cnt;
            if (k == 2) div_limit = 20'd2;
            step = 1'b1; run(3);
            step = 1'b0; run(8);
            check(rise_cnt == base + 1, "R5 one step one pulse", rise_cnt, base + 1);
        end
        div_limit = '0;

        cur_req = "R6";
        hold = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step = ~step; run(3);
        end
        step = 1'b0;
        run(6);
        check(last_int == 2, "R6 step ignored while running", last_int, 2);

        cur_req = "R9";
        hold = 1'b1;
        run(6);
        base = rise_cnt;
        step = 1'b1;
        run(2);
        rst = 1'b1;
        step = 1'b0;
        run(3);
        rst = 1'b0;
        run(12);
        check(rise_cnt == base, "R9 reset drops pending step", rise_cnt, base);

        cur_req = "R8";
        hold = 1'b0;
        run(12);
        check(last_int == 2, "R8 resume ungated", last_int, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule